// File: doc/BRIEF.md
# Daisy-Chain Configuration Slave

This block is the serial configuration front end of one device in a chain of configurable devices. All devices in the chain share one configuration clock (`cclk`) and one initialisation signal (`init_n`). Each device samples its serial input on the rising clock edge. It first waits for a header marker, then captures a 24-bit length count. Next it takes its own fixed number of data frames and hands each one out in parallel. After that it becomes transparent and passes every later bit to its serial output, which feeds the next device in the chain.

The header is passed on to the next device, so every device captures the same length count. While a device is still taking its own frames, it drives its serial output high. The next device reads this as idle and keeps waiting for its first frame start bit. Completion does not depend on how much data a device has received. Each device counts configuration clocks from the release of `init_n` and compares that count with the length count. Every device in the chain therefore raises `done` on the same clock edge and releases its I/O one clock later.

Each stage adds one clock of delay between `din` and `dout`. The length count written into the stream must include the extra clocks that the last device in the chain needs.

Top module: `cfg_chain_slave`

## Requirements
- R1: While `init_n` is low, `dout` is 1 and `done`, `io_release`, `frame_valid` and `frame_err` are all 0.
- R2: The header is found when the last four sampled bits are 0,0,1,0 (oldest first). Any number of leading ones, idle or filler, is ignored. The 24-bit length count follows immediately, most significant bit first.
- R3: From reset up to and including the last length-count bit, `dout` equals the `din` value sampled one `cclk` edge earlier.
- R4: After the length field, `dout` is held at 1 while the device reads its 4 trailing filler bits and its own frames, and also after a fault.
- R5: Ones seen before the first frame start bit are ignored. A frame is a 0 start bit followed by FRAME_BITS data bits, most significant bit first. `frame_valid` is a one-cycle pulse in the cycle after the last data bit is sampled, with the frame on `frame_data`. Exactly FRAME_COUNT frames are taken.
- R6: Once the device's own frames are complete, `dout` equals the `din` value sampled one `cclk` edge earlier.
- R7: After the first frame, a 1 where a start bit is expected sets `frame_err`. The flag stays set until reset, and no further frame is accepted.
- R8: If the length count is L, `done` is 0 after clock edge L (counted from the release of `init_n`) and 1 after edge L+1.
- R9: `io_release` rises one clock after `done`. Both stay high until `init_n` goes low.
- R10: In a chain of devices with a shared `cclk` and `init_n`, each device loads its own frames, and all devices raise `done` on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cclk | input | 1 | Configuration clock; `din` is sampled on the rising edge |
| init_n | input | 1 | Active-low initialisation; asserted asynchronously, released synchronously |
| din | input | 1 | Serial configuration input |
| dout | output | 1 | Serial output to the next device in the chain |
| frame_data | output | FRAME_BITS | Last frame loaded by this device |
| frame_valid | output | 1 | One-cycle strobe marking a new `frame_data` value |
| frame_err | output | 1 | Sticky flag for a missing frame start bit |
| done | output | 1 | Configuration complete |
| io_release | output | 1 | I/O enable, one clock after `done` |

## Verification
The hardest cases to reach are the second and third devices. Their input is the first device's output, so they see a long run of masked ones between their trailing filler and their first start bit. They must wait through that run without raising an error. The bench builds one stream for three chained instances, with the frames for each device placed in order and a length count that covers the two clocks of chain delay. It checks every loaded frame against a scoreboard and checks that all three `done` outputs rise together. A second stream breaks the start bit after one good frame. This case shows that the error is sticky, that loading stops, and that completion still follows only the clock count.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

  typedef enum logic [2:0] {
    ST_SEEK  = 3'd0,  // hunting for the header marker
    ST_LEN   = 3'd1,  // shifting in the length count
    ST_TRAIL = 3'd2,  // trailing header filler
    ST_OWN   = 3'd3,  // absorbing this device's frames
    ST_PASS  = 3'd4,  // transparent, forwarding to the next device
    ST_FAULT = 3'd5   // start bit missing, frozen
  } cfg_state_e;

  localparam logic [3:0] HDR_MARK = 4'b0010;

endpackage

// File: rtl/cfg_frame_fsm.sv
module cfg_frame_fsm
  import cfg_chain_pkg::*;
#(
  parameter int FRAME_BITS  = 8,
  parameter int FRAME_COUNT = 2,
  parameter int LEN_W       = 24,
  parameter int TRAIL_BITS  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  din,
  output logic                  dout,
  output logic [LEN_W-1:0]      len_value,
  output logic                  len_valid,
  output logic [FRAME_BITS-1:0] frame_data,
  output logic                  frame_valid,
  output logic                  frame_err,
  output logic                  absorbing
);

  localparam int MAX_A = (LEN_W > FRAME_BITS) ? LEN_W : FRAME_BITS;
  localparam int MAXF  = (MAX_A > TRAIL_BITS) ? MAX_A : TRAIL_BITS;
  localparam int POS_W = $clog2(MAXF + 1);
  localparam int FC_W  = $clog2(FRAME_COUNT + 1);

  cfg_state_e            state_q, state_d;
  logic [POS_W-1:0]      pos_q, pos_d;
  logic [2:0]            win_q, win_d;
  logic [LEN_W-1:0]      len_q, len_d;
  logic                  lvld_q, lvld_d;
  logic [FRAME_BITS-2:0] shf_q, shf_d;
  logic [FC_W-1:0]       fcnt_q, fcnt_d;
  logic [FRAME_BITS-1:0] fdat_q, fdat_d;
  logic                  fval_q, fval_d;
  logic                  ferr_q, ferr_d;
  logic                  dout_q, dout_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    win_d   = win_q;
    len_d   = len_q;
    lvld_d  = lvld_q;
    shf_d   = shf_q;
    fcnt_d  = fcnt_q;
    fdat_d  = fdat_q;
    fval_d  = 1'b0;
    ferr_d  = ferr_q;
    dout_d  = 1'b1;
    unique case (state_q)
      ST_SEEK: begin
        dout_d = din;
        win_d  = {win_q[1:0], din};
        if ({win_q, din} == HDR_MARK) begin
          state_d = ST_LEN;
          pos_d   = '0;
        end
      end
      ST_LEN: begin
        dout_d = din;
        len_d  = {len_q[LEN_W-2:0], din};
        if (pos_q == POS_W'(LEN_W - 1)) begin
          state_d = ST_TRAIL;
          pos_d   = '0;
          lvld_d  = 1'b1;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
      ST_TRAIL: begin
        if (pos_q == POS_W'(TRAIL_BITS - 1)) begin
          state_d = ST_OWN;
          pos_d   = '0;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
      ST_OWN: begin
        if (pos_q == '0) begin
          if (!din) begin
            pos_d = POS_W'(1);
          end else if (fcnt_q != '0) begin
            state_d = ST_FAULT;
            ferr_d  = 1'b1;
          end
        end else if (pos_q == POS_W'(FRAME_BITS)) begin
          fdat_d = {shf_q, din};
          fval_d = 1'b1;
          pos_d  = '0;
          fcnt_d = fcnt_q + 1'b1;
          if (fcnt_q == FC_W'(FRAME_COUNT - 1)) state_d = ST_PASS;
        end else begin
          shf_d = {shf_q[FRAME_BITS-3:0], din};
          pos_d = pos_q + 1'b1;
        end
      end
      ST_PASS:  dout_d = din;
      ST_FAULT: dout_d = 1'b1;
      default:  state_d = ST_FAULT;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEEK;
      pos_q   <= '0;
      win_q   <= '1;
      len_q   <= '0;
      lvld_q  <= 1'b0;
      shf_q   <= '0;
      fcnt_q  <= '0;
      fdat_q  <= '0;
      fval_q  <= 1'b0;
      ferr_q  <= 1'b0;
      dout_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      win_q   <= win_d;
      len_q   <= len_d;
      lvld_q  <= lvld_d;
      shf_q   <= shf_d;
      fcnt_q  <= fcnt_d;
      fdat_q  <= fdat_d;
      fval_q  <= fval_d;
      ferr_q  <= ferr_d;
      dout_q  <= dout_d;
    end
  end

  assign dout        = dout_q;
  assign len_value   = len_q;
  assign len_valid   = lvld_q;
  assign frame_data  = fdat_q;
  assign frame_valid = fval_q;
  assign frame_err   = ferr_q;
  assign absorbing   = (state_q == ST_TRAIL) || (state_q == ST_OWN) ||
                       (state_q == ST_FAULT);

endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq #(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len_value,
  input  logic             len_valid,
  output logic             done,
  output logic             io_release
);

  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             match;
  logic             done_q, done_d;
  logic             rel_q, rel_d;

  // clock count since init, saturating so it never wraps back onto a match
  assign cnt_en = (cnt_q != '1);
  assign match  = len_valid && (cnt_q == len_value);

  always_comb begin
    cnt_d  = cnt_en ? cnt_q + 1'b1 : cnt_q;
    done_d = done_q | match;
    rel_d  = rel_q | done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      rel_q  <= rel_d;
    end
  end

  assign done       = done_q;
  assign io_release = rel_q;

endmodule

// File: rtl/cfg_chain_slave.sv
module cfg_chain_slave #(
  parameter int FRAME_BITS  = 8,
  parameter int FRAME_COUNT = 2,
  parameter int LEN_W       = 24,
  parameter int TRAIL_BITS  = 4
) (
  input  logic                  cclk,
  input  logic                  init_n,
  input  logic                  din,
  output logic                  dout,
  output logic [FRAME_BITS-1:0] frame_data,
  output logic                  frame_valid,
  output logic                  frame_err,
  output logic                  done,
  output logic                  io_release
);

  logic [LEN_W-1:0] len_value;
  logic             len_valid;
  logic             absorbing;

  cfg_frame_fsm #(
    .FRAME_BITS (FRAME_BITS),
    .FRAME_COUNT(FRAME_COUNT),
    .LEN_W      (LEN_W),
    .TRAIL_BITS (TRAIL_BITS)
  ) u_fsm (
    .clk        (cclk),
    .rst_n      (init_n),
    .din        (din),
    .dout       (dout),
    .len_value  (len_value),
    .len_valid  (len_valid),
    .frame_data (frame_data),
    .frame_valid(frame_valid),
    .frame_err  (frame_err),
    .absorbing  (absorbing)
  );

  cfg_startup_seq #(
    .LEN_W(LEN_W)
  ) u_seq (
    .clk       (cclk),
    .rst_n     (init_n),
    .len_value (len_value),
    .len_valid (len_valid),
    .done      (done),
    .io_release(io_release)
  );

endmodule

// File: rtl/cfg_chain_checker.sv
module cfg_chain_checker (
  input logic clk,
  input logic rst_n,
  input logic dout,
  input logic done,
  input logic io_release,
  input logic frame_valid,
  input logic frame_err,
  input logic absorbing
);

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);  // R9

  AST_RELEASE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |=> $rose(io_release));  // R9

  AST_RELEASE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    io_release |-> done);  // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);  // R7

  AST_NO_LOAD_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !frame_valid);  // R7

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);  // R5

  AST_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    absorbing |=> dout);  // R4

endmodule

bind cfg_chain_slave cfg_chain_checker u_chk (
  .clk        (cclk),
  .rst_n      (init_n),
  .dout       (dout),
  .done       (done),
  .io_release (io_release),
  .frame_valid(frame_valid),
  .frame_err  (frame_err),
  .absorbing  (absorbing)
);

// File: tb/tb_cfg_chain_slave.sv
module tb_cfg_chain_slave;

  localparam int CLK_PERIOD = 10;
  localparam int FB = 8;
  localparam int FC = 2;
  localparam int WATCHDOG = 20000;

  logic cclk = 1'b0;
  logic init_n = 1'b0;
  logic din = 1'b1;

  logic          d0, d1, d2;
  logic [FB-1:0] f0, f1, f2;
  logic          v0, v1, v2, e0, e1, e2, dn0, dn1, dn2, r0, r1, r2;

  always #(CLK_PERIOD/2) cclk = ~cclk;

  cfg_chain_slave #(.FRAME_BITS(FB), .FRAME_COUNT(FC)) dut (
    .cclk(cclk), .init_n(init_n), .din(din), .dout(d0), .frame_data(f0),
    .frame_valid(v0), .frame_err(e0), .done(dn0), .io_release(r0));
  cfg_chain_slave #(.FRAME_BITS(FB), .FRAME_COUNT(FC)) dut_mid (
    .cclk(cclk), .init_n(init_n), .din(d0), .dout(d1), .frame_data(f1),
    .frame_valid(v1), .frame_err(e1), .done(dn1), .io_release(r1));
  cfg_chain_slave #(.FRAME_BITS(FB), .FRAME_COUNT(FC)) dut_tail (
    .cclk(cclk), .init_n(init_n), .din(d1), .dout(d2), .frame_data(f2),
    .frame_valid(v2), .frame_err(e2), .done(dn2), .io_release(r2));

  logic          stream [0:511];
  logic          exp_do [0:511];
  int            slen;
  int            n_chk = 0;
  int            n_bad = 0;
  logic [FB-1:0] q0[$];
  logic [FB-1:0] q1[$];
  logic [FB-1:0] q2[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic add_bit(logic b, logic fwd);
    stream[slen] = b;
    exp_do[slen] = fwd ? b : 1'b1;
    slen++;
  endtask

  task automatic add_bits(logic [31:0] v, int n, logic fwd);
    for (int k = n - 1; k >= 0; k--) add_bit(v[k], fwd);
  endtask

  // dev < 0: frame is not expected to be loaded by anyone
  task automatic add_frame(int dev, logic [FB-1:0] v, logic fwd);
    add_bit(1'b0, fwd);
    add_bits(32'(v), FB, fwd);
    case (dev)
      0: q0.push_back(v);
      1: q1.push_back(v);
      2: q2.push_back(v);
      default: ;
    endcase
  endtask

  task automatic add_header(int idle, logic [23:0] len);
    add_bits('1, idle, 1'b1);
    add_bits('1, 8, 1'b1);
    add_bits(32'b0010, 4, 1'b1);   // R2 marker
    add_bits(32'(len), 24, 1'b1);  // R2 length, MSB first
    add_bits('1, 4, 1'b0);         // R4 trailing filler held high
  endtask

  task automatic pop_cmp(int dev, logic [FB-1:0] got);
    logic [FB-1:0] want;
    n_chk++;
    case (dev)
      0: if (q0.size() == 0) want = 'x; else want = q0.pop_front();
      1: if (q1.size() == 0) want = 'x; else want = q1.pop_front();
      default: if (q2.size() == 0) want = 'x; else want = q2.pop_front();
    endcase
    if (want === 'x) begin
      n_bad++;
      $display("FAIL R5/R7 device %0d unexpected frame: actual %0h expected none", dev, got);
    end else if (got !== want) begin
      n_bad++;
      $display("FAIL R5 R10 device %0d frame: actual %0h expected %0h", dev, got, want);
    end
  endtask

  // scoreboard monitor
  always @(negedge cclk) begin
    if (init_n) begin
      if (v0) pop_cmp(0, f0);
      if (v1) pop_cmp(1, f1);
      if (v2) pop_cmp(2, f2);
    end
  end

  task automatic do_reset();
    init_n = 1'b0;
    din = 1'b1;
    repeat (3) @(negedge cclk);
    check("R1", {dn0, dn1, dn2}, 3'b000, "done in reset");
    check("R1", {r0, r1, r2}, 3'b000, "io_release in reset");
    check("R1", {v0, e0, v1, e1, v2, e2}, 6'b0, "valid/err in reset");
    check("R1", {d0, d1, d2}, 3'b111, "dout in reset");
  endtask

  // drive L edges; bit i is sampled on edge i+1
  task automatic run_stream(int len);
    for (int i = 0; i < len; i++) begin
      @(negedge cclk);
      if (i == 0) init_n = 1'b1;
      if (i > 0 && i - 1 < slen)
        check("R3/R4/R6", 32'(d0), 32'(exp_do[i-1]), "dout of first device");
      if (i > 0) check("R8", 32'(dn0), 32'd0, "done before length match");
      din = (i < slen) ? stream[i] : 1'b1;
    end
    @(negedge cclk);  // after edge L
    if (len - 1 < slen) check("R6", 32'(d0), 32'(exp_do[len-1]), "dout last bit");
    check("R8", {dn0, dn1, dn2}, 3'b000, "done after edge L");
    @(negedge cclk);  // after edge L+1
    check("R8 R10", {dn0, dn1, dn2}, 3'b111, "done after edge L+1");
    check("R9", {r0, r1, r2}, 3'b000, "io_release with done");
    @(negedge cclk);  // after edge L+2
    check("R9", {r0, r1, r2}, 3'b111, "io_release one clock after done");
  endtask

  initial begin
    int len_a;
    // ---- chain load: three devices, idle ones before the header (R2, R10)
    slen = 0;
    len_a = 3 + 40 + 3 * FC * (FB + 1) + 2;
    add_header(3, 24'(len_a));
    add_frame(0, 8'hA5, 1'b0);
    add_frame(0, 8'h3C, 1'b0);
    add_frame(1, 8'h00, 1'b1);
    add_frame(1, 8'h81, 1'b1);
    add_frame(2, 8'h7E, 1'b1);
    add_frame(2, 8'hC3, 1'b1);
    add_bits('1, 2, 1'b1);
    do_reset();
    run_stream(len_a);
    check("R5 R10", 32'(q0.size() + q1.size() + q2.size()), 32'd0, "frames left unloaded");
    check("R7", {e0, e1, e2}, 3'b000, "no error in good chain");
    repeat (4) @(negedge cclk);
    check("R9", {dn0, dn1, dn2, r0, r1, r2}, 6'b111111, "done/io_release hold");
    check("R5", 32'(f0), 32'h3C, "first device keeps last frame");

    // ---- broken start bit after one good frame (R7), length 80 (R8)
    slen = 0;
    add_header(2, 24'd80);
    add_frame(0, 8'h96, 1'b0);
    add_bit(1'b1, 1'b0);            // missing start bit
    add_bits(32'h55, FB, 1'b0);
    add_frame(-1, 8'h0F, 1'b0);     // must not be loaded
    do_reset();
    run_stream(80);
    check("R7", 32'(e0), 32'd1, "sticky error after missing start bit");
    check("R7", 32'(q0.size()), 32'd0, "good frame before the error loaded");
    check("R7", 32'(f0), 32'h96, "frame data unchanged after error");
    check("R4 R7", 32'(d0), 32'd1, "dout held high after fault");

    do_reset();  // R9: reset clears done and io_release
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge cclk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule